// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is the control engine of one DMA channel. It holds a working source address, a working destination address and a 24-bit transfer count, along with a backup copy of each. Software sets these up through a small register port, together with a channel control word and a global control word. Once enabled, the channel takes transfer requests from an internal automatic source or from an external request line. For each accepted request it runs one transfer unit. A unit is a bus cycle that the block opens with a strobe and that the system closes with a done pulse.

Each unit lowers the count and advances both addresses by a fixed step equal to the unit size in bytes. When the count runs out, the selected mode decides what happens next. Normal mode stops and flags completion. Repeat mode restores the addresses and the count from their backups and carries on, and it can flag the half-way point. Reload mode restores the addresses and refills the low count byte from the top count byte. A non-maskable event or an address error sets a global abort flag, and that flag blocks every further transfer until software clears it.

Top module: `dma_seq_chan`

## Requirements
- R1: After reset, all registers read 0, `busStart` is 0 and `irq` is 0. Register addresses: 0 source, 1 destination, 2 count, 3 source backup, 4 destination backup, 5 count backup, 6 channel control, 7 global control.
- R2: Each completed unit (`busStart` high and `busDone` high at a clock edge) lowers the count by 1 and adds UNIT_BYTES (default 4) to the source and destination addresses.
- R3: In normal mode (channel control bits 6:5 = 0), the unit that takes the count to 0 sets the end flag (channel control bit 3), and no further unit starts.
- R4: `irq` is high while (end flag and interrupt enable, bit 1) or (half flag, bit 4, and half interrupt enable, bit 2).
- R5: A unit starts only when channel enable (control bit 0) and master enable (global bit 0) are both 1, the NMI flag (global bit 1) and the address-error flag (global bit 2) are both 0, and the end flag is 0 (see R10 for the exception).
- R6: A pulse on `nmiIn` or `addrErrIn` sets the matching global flag. A unit already on the bus completes, and no further unit starts.
- R7: The end, half, NMI and address-error flags are cleared only by writing 0 to their bit. Writing 1 leaves them unchanged.
- R8: In repeat mode (bits 6:5 = 1) with half interrupt enable set, the unit that takes the count to half of the count backup sets the half flag.
- R9: In repeat mode, the unit that takes the count to 0 instead loads the count, source and destination from their backups.
- R10: In repeat mode, a request is accepted even while the end flag is 1, provided half interrupt enable is 1 and the half flag is 0.
- R11: In reload mode (bits 6:5 = 2), each unit lowers only count bits 7:0. When they reach 0 they are loaded from count bits 23:16, and both addresses are loaded from their backups.
- R12: With automatic request (bit 9) off and burst (bit 7) off, `extReq` is level-sensed and one unit runs per request, with `busStart` dropping between units.
- R13: With burst and edge detection (bit 8) set, one rising edge of `extReq` starts units that run back to back, with `busStart` held high, until the end.
- R14: When a unit sets a flag in the same cycle that software writes 0 to that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| extReq | input | 1 | External transfer request |
| reqAck | output | 1 | Request accepted this cycle |
| nmiIn | input | 1 | Non-maskable abort event |
| addrErrIn | input | 1 | Address error event |
| busStart | output | 1 | Bus cycle for one unit is open |
| busDone | input | 1 | Bus cycle complete |
| busSrc | output | 32 | Current source address |
| busDst | output | 32 | Current destination address |
| irq | output | 1 | End or half-end interrupt |

## Verification
Two actions can land in the same cycle. One is a unit that finishes and sets the end flag. The other is a software write of 0 to that same control word. The bench provokes this by keeping the channel on its last unit and raising `busDone` on the same edge as a channel-control write that clears the end bit. It then reads back the control word and expects the end flag to still be set. A second pairing also gets a directed test: an abort event raised while a unit is on the bus. In that case the count must show that the unit in flight completed, and no unit may follow.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPARE  = 2'd3
  } xferMode_e;

  localparam logic [2:0] REG_SRC    = 3'd0;
  localparam logic [2:0] REG_DST    = 3'd1;
  localparam logic [2:0] REG_CNT    = 3'd2;
  localparam logic [2:0] REG_SRC_BK = 3'd3;
  localparam logic [2:0] REG_DST_BK = 3'd4;
  localparam logic [2:0] REG_CNT_BK = 3'd5;
  localparam logic [2:0] REG_CTRL   = 3'd6;
  localparam logic [2:0] REG_GLOB   = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic step;
  } seqStrobe_t;

  // summary from datapath to control
  typedef struct packed {
    logic permit;
    logic reqValid;
    logic burst;
    logic lastUnit;
  } chanStatus_t;

endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int UNIT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic [2:0]        rdAddr,
  output logic [31:0]       rdData,
  input  logic              extReq,
  input  logic              nmiIn,
  input  logic              addrErrIn,
  input  seqStrobe_t        strobe,
  output chanStatus_t       status,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(UNIT_BYTES);
  localparam int HI_LSB = CNT_W - 8;

  logic [ADDR_W-1:0] srcQ, dstQ, srcBkQ, dstBkQ;
  logic [CNT_W-1:0]  cntQ, cntBkQ;
  logic chanEnQ, intEnQ, halfIeQ, endFlagQ, halfFlagQ;
  logic burstQ, edgeQ, autoQ;
  xferMode_e modeQ;
  logic masterEnQ, nmiFlagQ, aerrFlagQ;
  logic pendQ, reqDlyQ;

  logic wrCtrl, wrGlob;
  logic [CNT_W-1:0] cntDec, cntNext;
  logic [7:0] lowDec;
  logic isRepeat, isReload, isNormal;
  logic reloadAddr, endHit, halfHit;

  assign wrCtrl   = wrEn && (wrAddr == REG_CTRL);
  assign wrGlob   = wrEn && (wrAddr == REG_GLOB);
  assign isRepeat = (modeQ == MODE_REPEAT);
  assign isReload = (modeQ == MODE_RELOAD);
  assign isNormal = !isRepeat && !isReload;

  assign cntDec = cntQ - CNT_W'(1);
  assign lowDec = cntQ[7:0] - 8'd1;

  always_comb begin
    reloadAddr = 1'b0;
    cntNext    = cntDec;
    if (isRepeat) begin
      if (cntDec == '0) begin
        cntNext    = cntBkQ;
        reloadAddr = 1'b1;
      end
    end else if (isReload) begin
      cntNext = {cntQ[CNT_W-1:8], lowDec};
      if (lowDec == 8'd0) begin
        cntNext    = {cntQ[CNT_W-1:8], cntQ[CNT_W-1:HI_LSB]};
        reloadAddr = 1'b1;
      end
    end
  end

  assign endHit  = strobe.step && isNormal && (cntDec == '0);
  assign halfHit = strobe.step && isRepeat && halfIeQ && (cntDec == (cntBkQ >> 1));

  // addresses
  always_ff @(posedge clk) begin
    if (rst) begin
      srcQ <= '0;
      dstQ <= '0;
    end else if (strobe.step) begin
      if (reloadAddr) begin
        srcQ <= srcBkQ;
        dstQ <= dstBkQ;
      end else begin
        srcQ <= srcQ + STEP;
        dstQ <= dstQ + STEP;
      end
    end else begin
      if (wrEn && wrAddr == REG_SRC) srcQ <= wrData[ADDR_W-1:0];
      if (wrEn && wrAddr == REG_DST) dstQ <= wrData[ADDR_W-1:0];
    end
  end

  // count and backups
  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ   <= '0;
      cntBkQ <= '0;
      srcBkQ <= '0;
      dstBkQ <= '0;
    end else begin
      if (strobe.step) cntQ <= cntNext;
      else if (wrEn && wrAddr == REG_CNT) cntQ <= wrData[CNT_W-1:0];
      if (wrEn && wrAddr == REG_CNT_BK) cntBkQ <= wrData[CNT_W-1:0];
      if (wrEn && wrAddr == REG_SRC_BK) srcBkQ <= wrData[ADDR_W-1:0];
      if (wrEn && wrAddr == REG_DST_BK) dstBkQ <= wrData[ADDR_W-1:0];
    end
  end

  // control word: hardware set of a flag beats a software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      chanEnQ   <= 1'b0;
      intEnQ    <= 1'b0;
      halfIeQ   <= 1'b0;
      endFlagQ  <= 1'b0;
      halfFlagQ <= 1'b0;
      modeQ     <= MODE_NORMAL;
      burstQ    <= 1'b0;
      edgeQ     <= 1'b0;
      autoQ     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        chanEnQ <= wrData[0];
        intEnQ  <= wrData[1];
        halfIeQ <= wrData[2];
        modeQ   <= xferMode_e'(wrData[6:5]);
        burstQ  <= wrData[7];
        edgeQ   <= wrData[8];
        autoQ   <= wrData[9];
      end
      if (endHit) endFlagQ <= 1'b1;
      else if (wrCtrl) endFlagQ <= endFlagQ & wrData[3];
      if (halfHit) halfFlagQ <= 1'b1;
      else if (wrCtrl) halfFlagQ <= halfFlagQ & wrData[4];
    end
  end

  // global word
  always_ff @(posedge clk) begin
    if (rst) begin
      masterEnQ <= 1'b0;
      nmiFlagQ  <= 1'b0;
      aerrFlagQ <= 1'b0;
    end else begin
      if (wrGlob) masterEnQ <= wrData[0];
      if (nmiIn) nmiFlagQ <= 1'b1;
      else if (wrGlob) nmiFlagQ <= nmiFlagQ & wrData[1];
      if (addrErrIn) aerrFlagQ <= 1'b1;
      else if (wrGlob) aerrFlagQ <= aerrFlagQ & wrData[2];
    end
  end

  // external request edge capture
  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ   <= 1'b0;
      reqDlyQ <= 1'b0;
    end else begin
      reqDlyQ <= extReq;
      pendQ   <= (pendQ && !strobe.accept) || (extReq && !reqDlyQ);
    end
  end

  always_comb begin
    status.permit   = chanEnQ && masterEnQ && !nmiFlagQ && !aerrFlagQ &&
                      (!endFlagQ || (isRepeat && halfIeQ && !halfFlagQ));
    status.reqValid = autoQ || ((burstQ && edgeQ) ? pendQ : extReq);
    status.burst    = burstQ;
    status.lastUnit = isNormal && (cntQ == CNT_W'(1));
  end

  always_comb begin
    case (rdAddr)
      REG_SRC:    rdData = 32'(srcQ);
      REG_DST:    rdData = 32'(dstQ);
      REG_CNT:    rdData = 32'(cntQ);
      REG_SRC_BK: rdData = 32'(srcBkQ);
      REG_DST_BK: rdData = 32'(dstBkQ);
      REG_CNT_BK: rdData = 32'(cntBkQ);
      REG_CTRL:   rdData = {22'd0, autoQ, edgeQ, burstQ, modeQ, halfFlagQ,
                            endFlagQ, halfIeQ, intEnQ, chanEnQ};
      default:    rdData = {29'd0, aerrFlagQ, nmiFlagQ, masterEnQ};
    endcase
  end

  assign srcAddr = srcQ;
  assign dstAddr = dstQ;
  assign irq     = (endFlagQ && intEnQ) || (halfFlagQ && halfIeQ);

  a_r2_count_drop: assert property (@(posedge clk) disable iff (rst)
    strobe.step && isNormal && (cntQ > CNT_W'(1)) |=> cntQ == $past(cntQ) - CNT_W'(1));

  a_r3_end_flag: assert property (@(posedge clk) disable iff (rst)
    strobe.step && isNormal && (cntQ == CNT_W'(1)) |=> endFlagQ);

  a_r9_repeat_restore: assert property (@(posedge clk) disable iff (rst)
    strobe.step && isRepeat && (cntQ == CNT_W'(1)) |=> srcQ == $past(srcBkQ));

  a_r7_end_sticky: assert property (@(posedge clk) disable iff (rst)
    endFlagQ && !wrCtrl |=> endFlagQ);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  chanStatus_t status,
  input  logic        nmiIn,
  input  logic        addrErrIn,
  input  logic        busDone,
  output seqStrobe_t  strobe,
  output logic        busStart,
  output logic        reqAck
);

  typedef enum logic {ST_IDLE, ST_BUS} seqState_e;
  seqState_e stateQ, stateD;
  logic keepGoing;

  assign strobe.accept = (stateQ == ST_IDLE) && status.permit && status.reqValid;
  assign strobe.step   = (stateQ == ST_BUS) && busDone;
  assign keepGoing     = status.burst && status.permit && !status.lastUnit &&
                         !nmiIn && !addrErrIn;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (strobe.accept) stateD = ST_BUS;
      default: if (busDone) stateD = keepGoing ? ST_BUS : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign busStart = (stateQ == ST_BUS);
  assign reqAck   = strobe.accept;

  a_r12_steal_release: assert property (@(posedge clk) disable iff (rst)
    strobe.step && !status.burst |=> !busStart);

  a_r6_abort_halts: assert property (@(posedge clk) disable iff (rst)
    strobe.step && (nmiIn || addrErrIn) |=> !busStart);

  a_r5_start_permitted: assert property (@(posedge clk) disable iff (rst)
    $rose(busStart) |-> $past(status.permit));

  a_r3_last_unit_stops: assert property (@(posedge clk) disable iff (rst)
    strobe.step && status.lastUnit |=> !busStart);

endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int UNIT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic [2:0]        rdAddr,
  output logic [31:0]       rdData,
  input  logic              extReq,
  output logic              reqAck,
  input  logic              nmiIn,
  input  logic              addrErrIn,
  output logic              busStart,
  input  logic              busDone,
  output logic [ADDR_W-1:0] busSrc,
  output logic [ADDR_W-1:0] busDst,
  output logic              irq
);

  seqStrobe_t  strobe;
  chanStatus_t status;

  dma_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .UNIT_BYTES(UNIT_BYTES)) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extReq(extReq), .nmiIn(nmiIn),
    .addrErrIn(addrErrIn), .strobe(strobe), .status(status),
    .srcAddr(busSrc), .dstAddr(busDst), .irq(irq)
  );

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .status(status), .nmiIn(nmiIn),
    .addrErrIn(addrErrIn), .busDone(busDone), .strobe(strobe),
    .busStart(busStart), .reqAck(reqAck)
  );

endmodule

// File: tb/dma_seq_chan_test.sv
module dma_seq_chan_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [2:0] rdAddr = 3'd0;
  logic [31:0] rdData;
  logic extReq = 1'b0, reqAck, nmiIn = 1'b0, addrErrIn = 1'b0;
  logic busStart, busDone = 1'b0, irq;
  logic [31:0] busSrc, busDst;

  int nTests = 0, nFail = 0, units = 0;
  bit autoResp = 1'b0, finished = 1'b0;

  localparam logic [31:0] C_EN = 32'h1, C_IE = 32'h2, C_HIE = 32'h4, C_END = 32'h8;
  localparam logic [31:0] C_REP = 32'h20, C_RLD = 32'h40, C_BURST = 32'h80;
  localparam logic [31:0] C_EDGE = 32'h100, C_AUTO = 32'h200;

  always #2 clk = ~clk;

  dma_seq_chan uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extReq(extReq), .reqAck(reqAck),
    .nmiIn(nmiIn), .addrErrIn(addrErrIn), .busStart(busStart),
    .busDone(busDone), .busSrc(busSrc), .busDst(busDst), .irq(irq)
  );

  // table: src, dst, count, burst flag
  typedef struct packed { logic [31:0] src; logic [31:0] dst; logic [31:0] cnt; logic burst; } vec_t;
  localparam vec_t VECS [4] = '{
    '{32'h1000, 32'h2000, 32'd3, 1'b0},
    '{32'h0000, 32'h8000, 32'd1, 1'b0},
    '{32'hFFF0, 32'h0010, 32'd5, 1'b1},
    '{32'h0400, 32'h0400, 32'd8, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; autoResp = 1'b0; busDone = 1'b0; extReq = 1'b0;
    nmiIn = 1'b0; addrErrIn = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // complete one unit by hand
  task automatic doUnit();
    @(negedge clk);
    for (int i = 0; i < 40 && !busStart; i++) @(negedge clk);
    busDone = 1'b1;
    @(negedge clk);
    busDone = 1'b0;
  endtask

  // count busStart rising edges over n cycles
  task automatic watch(input int n, output int rises);
    bit prev;
    prev = busStart;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busStart && !prev) rises++;
      prev = busStart;
    end
  endtask

  // automatic bus responder
  initial begin
    forever begin
      @(negedge clk);
      if (autoResp) begin
        if (busStart && !busDone) begin
          busDone = 1'b1;
          units++;
        end else busDone = 1'b0;
      end
    end
  end

  initial begin
    #400000;
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish();
  end

  initial begin
    logic [31:0] v;
    int rises;
    doReset();

    // R1 reset state
    rd(3'd6, v); check(v == 0, "R1 ctrl", v, 0);
    rd(3'd2, v); check(v == 0, "R1 count", v, 0);
    check(!busStart && !irq, "R1 outputs", {busStart, irq}, 0);

    // table walk: R2 R3 R4
    foreach (VECS[k]) begin
      doReset();
      wr(3'd0, VECS[k].src);
      wr(3'd1, VECS[k].dst);
      wr(3'd2, VECS[k].cnt);
      wr(3'd7, 32'h1);
      units = 0;
      autoResp = 1'b1;
      wr(3'd6, C_EN | C_IE | C_AUTO | (VECS[k].burst ? C_BURST : 32'h0));
      for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      autoResp = 1'b0;
      check(irq, "R4 end irq", irq, 1);
      check(units == VECS[k].cnt, "R3 unit count", units, VECS[k].cnt);
      rd(3'd0, v); check(v == VECS[k].src + VECS[k].cnt * 4, "R2 src", v, VECS[k].src + VECS[k].cnt * 4);
      rd(3'd1, v); check(v == VECS[k].dst + VECS[k].cnt * 4, "R2 dst", v, VECS[k].dst + VECS[k].cnt * 4);
      rd(3'd2, v); check(v == 0, "R2 count", v, 0);
      rd(3'd6, v); check(v[3], "R3 end flag", v[3], 1);
    end

    // R5 enables
    doReset();
    wr(3'd2, 32'd2);
    wr(3'd7, 32'h1);
    wr(3'd6, C_AUTO);
    watch(10, rises); check(rises == 0, "R5 channel off", rises, 0);
    wr(3'd7, 32'h0);
    wr(3'd6, C_AUTO | C_EN);
    watch(10, rises); check(rises == 0, "R5 master off", rises, 0);

    // R6 abort, R7 write-1 no effect / write-0 clears
    doReset();
    wr(3'd2, 32'd4);
    wr(3'd7, 32'h1);
    wr(3'd6, C_EN | C_AUTO);
    doUnit();
    @(negedge clk);
    nmiIn = 1'b1;
    @(negedge clk);
    nmiIn = 1'b0;
    doUnit();
    watch(10, rises); check(rises == 0 && !busStart, "R6 halted", rises, 0);
    rd(3'd2, v); check(v == 2, "R6 in-flight unit done", v, 2);
    rd(3'd7, v); check(v[1], "R6 nmi flag", v, 32'h3);
    wr(3'd7, 32'h3);
    rd(3'd7, v); check(v[1], "R7 write 1 keeps flag", v, 32'h3);
    watch(6, rises); check(rises == 0, "R7 still blocked", rises, 0);
    wr(3'd7, 32'h1);
    rd(3'd7, v); check(!v[1], "R7 write 0 clears", v, 32'h1);
    watch(6, rises); check(rises == 1, "R7 resumes", rises, 1);

    // R6 address error
    doReset();
    wr(3'd2, 32'd4);
    wr(3'd7, 32'h1);
    @(negedge clk);
    addrErrIn = 1'b1;
    @(negedge clk);
    addrErrIn = 1'b0;
    wr(3'd6, C_EN | C_AUTO);
    watch(10, rises); check(rises == 0, "R6 addr error blocks", rises, 0);

    // R8 half flag, R9 repeat restore
    doReset();
    wr(3'd0, 32'h100); wr(3'd1, 32'h200);
    wr(3'd3, 32'h100); wr(3'd4, 32'h200);
    wr(3'd2, 32'd4); wr(3'd5, 32'd4);
    wr(3'd7, 32'h1);
    wr(3'd6, C_EN | C_HIE | C_REP | C_AUTO);
    doUnit(); doUnit();
    rd(3'd6, v); check(v[4], "R8 half flag", v[4], 1);
    check(irq, "R8 half irq", irq, 1);
    rd(3'd0, v); check(v == 32'h108, "R8 src mid", v, 32'h108);
    doUnit(); doUnit();
    rd(3'd2, v); check(v == 4, "R9 count restored", v, 4);
    rd(3'd0, v); check(v == 32'h100, "R9 src restored", v, 32'h100);
    rd(3'd1, v); check(v == 32'h200, "R9 dst restored", v, 32'h200);

    // R10 repeat acceptance with end flag set
    doReset();
    wr(3'd2, 32'd1);
    wr(3'd7, 32'h1);
    wr(3'd6, C_EN | C_AUTO);
    doUnit();
    watch(5, rises); check(rises == 0, "R10 normal end stops", rises, 0);
    wr(3'd6, C_EN | C_AUTO | C_REP | C_END);
    watch(5, rises); check(rises == 0, "R10 no half enable", rises, 0);
    wr(3'd6, C_EN | C_AUTO | C_REP | C_HIE | C_END);
    rd(3'd6, v); check(v[3], "R10 end flag kept", v[3], 1);
    watch(5, rises); check(rises == 1, "R10 accepted", rises, 1);

    // R11 reload mode
    doReset();
    wr(3'd0, 32'h10); wr(3'd1, 32'h20);
    wr(3'd3, 32'h500); wr(3'd4, 32'h600);
    wr(3'd2, 32'h020002);
    wr(3'd7, 32'h1);
    wr(3'd6, C_EN | C_RLD | C_AUTO);
    doUnit(); doUnit();
    rd(3'd2, v); check(v == 32'h020002, "R11 low byte refill", v, 32'h020002);
    rd(3'd0, v); check(v == 32'h500, "R11 src restored", v, 32'h500);
    rd(3'd1, v); check(v == 32'h600, "R11 dst restored", v, 32'h600);
    doUnit();
    rd(3'd2, v); check(v == 32'h020001, "R11 next unit", v, 32'h020001);
    rd(3'd0, v); check(v == 32'h504, "R11 src step", v, 32'h504);

    // R12 cycle steal, level sensed
    doReset();
    wr(3'd2, 32'd3);
    wr(3'd7, 32'h1);
    wr(3'd6, C_EN);
    units = 0;
    autoResp = 1'b1;
    watch(10, rises); check(rises == 0, "R12 no request idle", rises, 0);
    extReq = 1'b1;
    watch(40, rises);
    extReq = 1'b0;
    check(rises == 3, "R12 separate bus cycles", rises, 3);
    check(units == 3, "R12 units", units, 3);

    // R13 burst, edge sensed
    doReset();
    wr(3'd2, 32'd3);
    wr(3'd7, 32'h1);
    wr(3'd6, C_EN | C_BURST | C_EDGE);
    units = 0;
    autoResp = 1'b1;
    @(negedge clk);
    extReq = 1'b1;
    @(negedge clk);
    extReq = 1'b0;
    watch(30, rises);
    check(rises == 1, "R13 one held bus cycle", rises, 1);
    check(units == 3, "R13 units", units, 3);
    rd(3'd6, v); check(v[3], "R13 end flag", v[3], 1);

    // R14 end set and software clear collide
    doReset();
    wr(3'd2, 32'd1);
    wr(3'd7, 32'h1);
    wr(3'd6, C_EN | C_AUTO);
    @(negedge clk);
    for (int i = 0; i < 20 && !busStart; i++) @(negedge clk);
    busDone = 1'b1;
    wrEn = 1'b1; wrAddr = 3'd6; wrData = C_EN | C_AUTO;
    @(negedge clk);
    busDone = 1'b0; wrEn = 1'b0;
    rd(3'd6, v); check(v[3], "R14 set beats clear", v[3], 1);

    finish();
  end

endmodule